// File: doc/BRIEF.md
# Address Translator with Fixed Kernel Window

This block turns 32-bit virtual addresses into physical addresses for a processor whose translation cache is filled by software. A fixed virtual range is handled without the cache: any address in it has a constant offset applied, so kernel code and data placed there can never take a translation miss. Every other address, while translation is enabled, is compared against a small fully associative table of 4 KiB page mappings. An address that matches no valid mapping is reported as a miss, and that address is kept in a fault register so the refill handler can read it.

Each request presented on `req_valid` is answered one clock later on `rsp_valid`. The result is held in a registered result state, which takes one of five values. `XK_IDLE` means no request was presented. `XK_BYPASS` means translation was disabled. `XK_WINDOW` means the address fell in the fixed window. `XK_HIT` means a table entry matched. `XK_MISS` means no entry matched. At every clock edge the state is reloaded from the request in front of it: no request leads to `XK_IDLE`. With a request, translation off leads to `XK_BYPASS`; otherwise an address in the window leads to `XK_WINDOW`, a match to `XK_HIT`, and anything else to `XK_MISS`. Any state can move to any other at the next edge.

Software loads a table slot with one write strobe that carries the slot index and both page numbers. A single-cycle strobe clears the valid flag of every slot.

Top module: `vmem_xlate`

## Requirements
- R1: After reset `rsp_valid` and `rsp_miss` are low, `bad_vaddr` is zero, and every table slot is invalid, so the first request outside the window misses.
- R2: A request sampled at a clock edge gives `rsp_valid` high for exactly the following cycle. A cycle with no request gives `rsp_valid` and `rsp_miss` low in the following cycle.
- R3: With `xlate_en` low, `rsp_paddr` equals the virtual address and `rsp_miss` stays low, whether or not the address is inside the window.
- R4: With `xlate_en` high, an address from 0xC000_0000 through 0xC7FF_FFFF gives `rsp_paddr` = address − 0xC000_0000 + 0x4000_0000 and never misses, even when a table slot maps the same page elsewhere.
- R5: With `xlate_en` high outside the window, a match gives `rsp_paddr` = {stored physical page number, address bits 11:0}. The virtual page number is address bits 31:12.
- R6: With `xlate_en` high outside the window and no valid match, `rsp_miss` is high and `rsp_paddr` is zero.
- R7: `bad_vaddr` takes the missing virtual address in the cycle `rsp_miss` is high. It is unchanged while no miss occurs, and a later miss overwrites it.
- R8: A write strobe with index 0..31 stores the virtual and physical page numbers in that slot and marks it valid. The new mapping applies to requests sampled from the next clock edge onward.
- R9: When several valid slots match, the slot with the lowest index supplies the physical page number.
- R10: An invalidate strobe clears every valid flag in one cycle. A write strobe in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| xlate_en | input | 1 | Translation enable; low passes addresses through |
| wr_en | input | 1 | Table slot write strobe |
| wr_index | input | 5 | Slot to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_ppn | input | 20 | Physical page number to store |
| inv_all | input | 1 | Clear all slot valid flags |
| rsp_valid | output | 1 | Result of last cycle's request is present |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_miss | output | 1 | Request matched no slot |
| bad_vaddr | output | 32 | Virtual address of the most recent miss |

## Verification
The bound checker watches the port-level rules on every cycle. These are the one-cycle request/response pairing, the pass-through when translation is off, the window arithmetic and the absence of misses inside the window, the capture and holding of the fault address, and a miss on the first out-of-window request after an invalidate. What a table hit returns can only be shown by the bench's scenarios, because it depends on earlier writes. The same is true of lowest-index priority among duplicate mappings, of the boundary slots 0 and 31, of window-edge addresses, and of a write being dropped when it meets an invalidate.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
    localparam int unsigned VA_W = 32;

    typedef enum logic [2:0] {
        XK_IDLE   = 3'd0,
        XK_BYPASS = 3'd1,
        XK_WINDOW = 3'd2,
        XK_HIT    = 3'd3,
        XK_MISS   = 3'd4
    } xlate_kind_e;
endpackage

// File: rtl/vmem_window.sv
// Fixed-offset range decode for the kernel window.
module vmem_window
    import vmem_pkg::*;
#(
    parameter logic [VA_W-1:0] WIN_VBASE = 32'hC000_0000,
    parameter logic [VA_W-1:0] WIN_BYTES = 32'h0800_0000,
    parameter logic [VA_W-1:0] WIN_PBASE = 32'h4000_0000
) (
    input  logic [VA_W-1:0] vaddr,
    output logic            in_win,
    output logic [VA_W-1:0] win_paddr
);
    logic [VA_W-1:0] offset;

    // An address below the base wraps to a large offset and fails the compare.
    always_comb begin
        offset    = vaddr - WIN_VBASE;
        in_win    = (offset < WIN_BYTES);
        win_paddr = offset + WIN_PBASE;
    end
endmodule

// File: rtl/vmem_tlb_array.sv
// Slot storage and parallel tag compare.
module vmem_tlb_array #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 20,
    parameter int unsigned IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_index,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               inv_all,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic [ENTRIES-1:0] match_vec,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic [PPN_W-1:0]   sel_ppn
);
    logic [VPN_W-1:0] vpn_q   [ENTRIES];
    logic [PPN_W-1:0] ppn_q   [ENTRIES];
    logic             valid_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic slot_wr;
        assign slot_wr = wr_en && (wr_index == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                vpn_q[g]   <= '0;
                ppn_q[g]   <= '0;
            end else if (inv_all) begin
                valid_q[g] <= 1'b0;
            end else if (slot_wr) begin
                valid_q[g] <= 1'b1;
                vpn_q[g]   <= wr_vpn;
                ppn_q[g]   <= wr_ppn;
            end
        end

        assign match_vec[g] = valid_q[g] && (vpn_q[g] == look_vpn);
    end

    assign sel_ppn = ppn_q[sel_idx];
endmodule

// File: rtl/vmem_prio.sv
// Lowest-index-wins encoder over the match vector.
module vmem_prio #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned IDX_W   = 5
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any_hit,
    output logic [IDX_W-1:0]   hit_idx
);
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vmem_xlate.sv
// Address translator: kernel window, associative page table cache, fault capture.
module vmem_xlate
    import vmem_pkg::*;
#(
    parameter int unsigned     ENTRIES   = 32,
    parameter int unsigned     PAGE_BITS = 12,
    parameter logic [VA_W-1:0] WIN_VBASE = 32'hC000_0000,
    parameter logic [VA_W-1:0] WIN_BYTES = 32'h0800_0000,
    parameter logic [VA_W-1:0] WIN_PBASE = 32'h4000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [VA_W-1:0]             req_vaddr,
    input  logic                        xlate_en,
    input  logic                        wr_en,
    input  logic [$clog2(ENTRIES)-1:0]  wr_index,
    input  logic [VA_W-PAGE_BITS-1:0]   wr_vpn,
    input  logic [VA_W-PAGE_BITS-1:0]   wr_ppn,
    input  logic                        inv_all,
    output logic                        rsp_valid,
    output logic [VA_W-1:0]             rsp_paddr,
    output logic                        rsp_miss,
    output logic [VA_W-1:0]             bad_vaddr
);
    localparam int unsigned VPN_W = VA_W - PAGE_BITS;
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    xlate_kind_e      st_q, st_d;
    logic [VA_W-1:0]  pa_q, pa_d;
    logic [VA_W-1:0]  bad_q;

    logic             in_win;
    logic [VA_W-1:0]  win_pa;
    logic [ENTRIES-1:0] match_vec;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic [VPN_W-1:0] hit_ppn;

    vmem_window #(
        .WIN_VBASE (WIN_VBASE),
        .WIN_BYTES (WIN_BYTES),
        .WIN_PBASE (WIN_PBASE)
    ) u_window (
        .vaddr     (req_vaddr),
        .in_win    (in_win),
        .win_paddr (win_pa)
    );

    vmem_tlb_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (VPN_W),
        .IDX_W   (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_index  (wr_index),
        .wr_vpn    (wr_vpn),
        .wr_ppn    (wr_ppn),
        .inv_all   (inv_all),
        .look_vpn  (req_vaddr[VA_W-1:PAGE_BITS]),
        .match_vec (match_vec),
        .sel_idx   (hit_idx),
        .sel_ppn   (hit_ppn)
    );

    vmem_prio #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_prio (
        .match_vec (match_vec),
        .any_hit   (any_hit),
        .hit_idx   (hit_idx)
    );

    // Next result state and address, decided from the current request.
    always_comb begin
        st_d = XK_IDLE;
        pa_d = '0;
        if (req_valid) begin
            if (!xlate_en) begin
                st_d = XK_BYPASS;
                pa_d = req_vaddr;
            end else if (in_win) begin
                st_d = XK_WINDOW;
                pa_d = win_pa;
            end else if (any_hit) begin
                st_d = XK_HIT;
                pa_d = {hit_ppn, req_vaddr[PAGE_BITS-1:0]};
            end else begin
                st_d = XK_MISS;
                pa_d = '0;
            end
        end
    end

    // State register, result address and fault capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= XK_IDLE;
            pa_q  <= '0;
            bad_q <= '0;
        end else begin
            st_q <= st_d;
            pa_q <= pa_d;
            if (st_d == XK_MISS) begin
                bad_q <= req_vaddr;
            end
        end
    end

    // Outputs decoded from the result state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_miss  = 1'b0;
        unique case (st_q)
            XK_IDLE:   begin rsp_valid = 1'b0; rsp_miss = 1'b0; end
            XK_BYPASS,
            XK_WINDOW,
            XK_HIT:    begin rsp_valid = 1'b1; rsp_miss = 1'b0; end
            XK_MISS:   begin rsp_valid = 1'b1; rsp_miss = 1'b1; end
            default:   begin rsp_valid = 1'b0; rsp_miss = 1'b0; end
        endcase
    end

    assign rsp_paddr = pa_q;
    assign bad_vaddr = bad_q;
endmodule

// File: rtl/vmem_xlate_chk.sv
// Port-level property checker, bound into every vmem_xlate instance.
module vmem_xlate_chk
    import vmem_pkg::*;
#(
    parameter logic [VA_W-1:0] WIN_VBASE = 32'hC000_0000,
    parameter logic [VA_W-1:0] WIN_BYTES = 32'h0800_0000,
    parameter logic [VA_W-1:0] WIN_PBASE = 32'h4000_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            xlate_en,
    input logic            inv_all,
    input logic            rsp_valid,
    input logic [VA_W-1:0] rsp_paddr,
    input logic            rsp_miss,
    input logic [VA_W-1:0] bad_vaddr
);
    logic [VA_W-1:0] req_off;
    logic            req_in_win;
    assign req_off    = req_vaddr - WIN_VBASE;
    assign req_in_win = req_off < WIN_BYTES;

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_miss));

    assert_bypass_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_en) |=> (!rsp_miss && rsp_paddr == $past(req_vaddr)));

    assert_window_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_en && req_in_win) |=>
            (!rsp_miss && rsp_paddr == $past(req_vaddr) - WIN_VBASE + WIN_PBASE));

    assert_miss_paddr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0));

    assert_bad_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (bad_vaddr == $past(req_vaddr)));

    assert_bad_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_miss |-> $stable(bad_vaddr));

    assert_inv_forces_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all ##1 (req_valid && xlate_en && !req_in_win) |=> rsp_miss);
endmodule

bind vmem_xlate vmem_xlate_chk #(
    .WIN_VBASE (WIN_VBASE),
    .WIN_BYTES (WIN_BYTES),
    .WIN_PBASE (WIN_PBASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .xlate_en  (xlate_en),
    .inv_all   (inv_all),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_miss  (rsp_miss),
    .bad_vaddr (bad_vaddr)
);

// File: tb/vmem_xlate_test.sv
`timescale 1ns/1ps
module vmem_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        xlate_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_index = '0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_ppn = '0;
    logic        inv_all = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_miss;
    logic [31:0] bad_vaddr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vmem_xlate uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_vaddr (req_vaddr), .xlate_en (xlate_en),
        .wr_en (wr_en), .wr_index (wr_index), .wr_vpn (wr_vpn), .wr_ppn (wr_ppn),
        .inv_all (inv_all),
        .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr),
        .rsp_miss (rsp_miss), .bad_vaddr (bad_vaddr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Present one request; sample the answer one edge later.
    task automatic lookup(input logic [31:0] va, input logic en,
                          output logic [31:0] pa, output logic miss, output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; xlate_en = en;
        @(negedge clk);
        pa = rsp_paddr; miss = rsp_miss; vld = rsp_valid;
        req_valid = 1'b0;
    endtask

    task automatic write_slot(input int idx, input logic [19:0] vpn, input logic [19:0] ppn);
        @(negedge clk);
        wr_en = 1'b1; wr_index = 5'(idx); wr_vpn = vpn; wr_ppn = ppn;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] va, input logic [31:0] exp_pa);
        logic [31:0] pa; logic miss, vld;
        lookup(va, 1'b1, pa, miss, vld);
        check(req, "valid", {31'd0, vld}, 32'd1);
        check(req, "miss", {31'd0, miss}, 32'd0);
        check(req, "paddr", pa, exp_pa);
    endtask

    task automatic expect_miss(input string req, input logic [31:0] va);
        logic [31:0] pa; logic miss, vld;
        lookup(va, 1'b1, pa, miss, vld);
        check(req, "miss", {31'd0, miss}, 32'd1);
        check(req, "paddr on miss", pa, 32'd0);
        check("R7", "bad address", bad_vaddr, va);
    endtask

    task automatic t_reset;
        check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1", "rsp_miss", {31'd0, rsp_miss}, 32'd0);
        check("R1", "bad_vaddr", bad_vaddr, 32'd0);
        expect_miss("R1", 32'h0001_0000);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        check("R2", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R2", "idle rsp_miss", {31'd0, rsp_miss}, 32'd0);
    endtask

    task automatic t_bypass;
        logic [31:0] pa; logic miss, vld;
        lookup(32'h1234_5678, 1'b0, pa, miss, vld);
        check("R3", "bypass paddr", pa, 32'h1234_5678);
        check("R3", "bypass miss", {31'd0, miss}, 32'd0);
        lookup(32'hC000_0040, 1'b0, pa, miss, vld);
        check("R3", "bypass window addr", pa, 32'hC000_0040);
    endtask

    task automatic t_window;
        expect_hit("R4", 32'hC000_0000, 32'h4000_0000);
        expect_hit("R4", 32'hC7FF_FFFF, 32'h47FF_FFFF);
        expect_hit("R4", 32'hC123_4568, 32'h4123_4568);
        expect_miss("R6", 32'hC800_0000);
        expect_miss("R6", 32'hBFFF_FFFF);
        // a slot mapping a window page is ignored
        write_slot(7, 20'hC0000, 20'h11111);
        expect_hit("R4", 32'hC000_0010, 32'h4000_0010);
    endtask

    task automatic t_bad_addr;
        logic [31:0] pa; logic miss, vld;
        expect_miss("R7", 32'h0BAD_0001);
        expect_miss("R7", 32'h0BAD_0002);
        lookup(32'h5555_0000, 1'b0, pa, miss, vld);
        check("R7", "bad address held", bad_vaddr, 32'h0BAD_0002);
    endtask

    task automatic t_hit;
        write_slot(3, 20'h12345, 20'hABCDE);
        expect_hit("R5", 32'h1234_5678, 32'hABCD_E678);
        write_slot(0, 20'h00001, 20'h7F000);
        expect_hit("R8", 32'h0000_1FFC, 32'h7F00_0FFC);
        write_slot(31, 20'hFFFFF, 20'h00042);
        expect_hit("R8", 32'hFFFF_F001, 32'h0004_2001);
    endtask

    task automatic t_write_timing;
        // request in the same cycle as the write sees the old contents
        logic [31:0] pa;
        @(negedge clk);
        wr_en = 1'b1; wr_index = 5'd12; wr_vpn = 20'h33333; wr_ppn = 20'h44444;
        req_valid = 1'b1; req_vaddr = 32'h3333_3010; xlate_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8", "same-cycle miss", {31'd0, rsp_miss}, 32'd1);
        @(negedge clk);
        pa = rsp_paddr;
        req_valid = 1'b0;
        check("R8", "next-cycle hit", {31'd0, rsp_miss}, 32'd0);
        check("R8", "next-cycle paddr", pa, 32'h4444_4010);
    endtask

    task automatic t_priority;
        write_slot(9, 20'h22222, 20'h99999);
        write_slot(5, 20'h22222, 20'h55555);
        expect_hit("R9", 32'h2222_2abc, 32'h5555_5abc);
        write_slot(5, 20'h66666, 20'h55555);
        expect_hit("R9", 32'h2222_2abc, 32'h9999_9abc);
    endtask

    task automatic t_invalidate;
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        expect_miss("R10", 32'h1234_5678);
        expect_miss("R10", 32'hFFFF_F001);
        expect_hit("R10", 32'hC000_1000, 32'h4000_1000);
        @(negedge clk);
        inv_all = 1'b1; wr_en = 1'b1; wr_index = 5'd2; wr_vpn = 20'h77777; wr_ppn = 20'h88888;
        @(negedge clk);
        inv_all = 1'b0; wr_en = 1'b0;
        expect_miss("R10", 32'h7777_7000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_bypass();
        t_window();
        t_bad_addr();
        t_hit();
        t_write_timing();
        t_priority();
        t_invalidate();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule